// File: doc/BRIEF.md
# Zero-Crossing Event Detector Bank

This block watches six streams of signed, already low-pass-filtered samples, three phase voltages and three phase currents, and flags every sign change of each stream with a single-clock event pulse. Each channel moves forward only on a clock where its own valid strobe is high. The filtered sample rate is typically 256 kHz, so strobes are sparse compared with the core clock. A sign change is any difference in sign between the current valid sample and the previous valid sample. Both rising and falling crossings count. A zero sample counts as non-negative.

Voltage channels reject noise. A crossing on a voltage channel is reported only if the largest magnitude seen during the half-cycle that the crossing closes reaches one tenth of a shared full-scale reference. Current channels report every crossing, whatever the amplitude.

For each channel the block also presents an amplitude-qualified flag, which tells whether the last completed half-cycle reached that threshold. The six event pulses are also placed in a status-aligned word, so that a status register can take them directly.

Top module: `zc_bank`

## Requirements
- R1: While reset is asserted, and on the first clocks after it is released, `zc_evt`, `amp_ok` and `zc_stat_word` are all zero.
- R2: The first valid sample that a channel receives after reset never produces an event, whatever its sign.
- R3: On a valid sample whose sign bit (bit DW-1, with zero counted as non-negative) differs from the sign of that channel's previous valid sample, the channel's `zc_evt` bit goes high on the clock after the strobe edge for exactly one clock. This applies to both rising and falling crossings, subject to R5.
- R4: A valid sample with the same sign as the previous valid sample produces no event. Samples presented without a strobe are ignored. They neither produce an event nor change the remembered sign.
- R5: On voltage channels (indices 0 to NPH-1), a crossing is suppressed if the half-cycle peak is below the threshold. The half-cycle peak is the largest absolute value among the valid samples from the previous crossing sample (or the first sample) up to, but not including, the crossing sample. The threshold is computed without a divider, and lies between 0.0999 and 0.1 of `full_scale`.
- R6: On current channels (indices NPH to 2*NPH-1), every crossing produces an event, including those of amplitude 1 LSB.
- R7: On every sign change, whether reported or suppressed, the channel's `amp_ok` bit takes the outcome of the half-cycle peak against the threshold. It does so in the same clock as the event pulse and keeps that value until the next sign change.
- R8: `zc_stat_word` carries the event of channel k at bit STAT_LSB+k, in the order VA, VB, VC, IA, IB, IC (bits 9 to 14 by default). All bits below STAT_LSB are zero.
- R9: Channels are independent. Simultaneous strobes on several channels give exactly the events that each channel would give on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 2*NPH | Per-channel sample strobe, bit k for channel k |
| smp_data | input | 2*NPH*DW | Signed samples, channel k in bits [k*DW +: DW] |
| full_scale | input | DW | Unsigned full-scale reference shared by the voltage channels |
| zc_evt | output | 2*NPH | One-clock crossing event per channel |
| amp_ok | output | 2*NPH | Last completed half-cycle reached the threshold |
| zc_stat_word | output | STAT_LSB+2*NPH | Events placed at their status bit positions |

## Verification
Every result of this block is due exactly one clock after the edge that samples a strobe. That one clock holds the event pulse, the updated `amp_ok` bit and the matching status bit. The event pulse must then be gone on the following clock. The bench drives each strobe for a single clock from a falling edge and compares all three outputs at the next falling edge. One clock later it confirms that the pulse has dropped. When no strobe is given, the bench looks at the outputs across the idle clocks to confirm that unstrobed data changed nothing. The threshold boundary is checked with amplitudes well clear of the divider-free approximation, at 5 % and 11 % of full scale.

// File: rtl/zc_pkg.sv
package zc_pkg;

  // kind of measurement channel fed to one detector
  typedef enum logic {
    ZC_VOLT = 1'b0,
    ZC_CURR = 1'b1
  } zc_kind_e;

  localparam int unsigned ZC_DW_DEF       = 24;
  localparam int unsigned ZC_NPH_DEF      = 3;
  localparam int unsigned ZC_STAT_LSB_DEF = 9;

endpackage

// File: rtl/zc_rst_sync.sv
module zc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/zc_thresh.sv
// Divider-free one-tenth of full scale:
// 1/10 = 3/32 * (1 + 1/16 + 1/256 + ...), i.e. pairs of shifts (4m, 4m+1).
module zc_thresh #(
  parameter int unsigned DW = 24
) (
  input  logic [DW-1:0] full_scale,
  output logic [DW-1:0] thr
);

  localparam int unsigned NTERM = (DW - 1) / 4;

  logic [DW-1:0] part [NTERM+1];

  assign part[0] = '0;

  for (genvar g = 0; g < NTERM; g++) begin : g_term
    localparam int unsigned SH = 4 * (g + 1);
    assign part[g+1] = part[g] + (full_scale >> SH) + (full_scale >> (SH + 1));
  end

  assign thr = part[NTERM];

  always_comb begin
    AST_THR_BELOW_FS: assert (thr <= full_scale); // R5
  end

endmodule

// File: rtl/zc_chan.sv
module zc_chan
  import zc_pkg::*;
#(
  parameter int unsigned DW   = ZC_DW_DEF,
  parameter zc_kind_e    KIND = ZC_VOLT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp,
  input  logic        [DW-1:0] thr,
  output logic                 evt,
  output logic                 amp_ok
);

  // state
  logic          prev_ok_q, prev_ok_d;
  logic          prev_neg_q, prev_neg_d;
  logic [DW-1:0] run_pk_q, run_pk_d;
  logic          evt_q, evt_d;
  logic          amp_q, amp_d;

  // datapath
  logic          cur_neg;
  logic [DW-1:0] smp_u;
  logic [DW-1:0] abs_cur;
  logic          sign_flip;
  logic          pk_pass;
  logic          gate;
  logic          fire;

  assign smp_u   = smp;
  assign cur_neg = smp[DW-1];
  assign abs_cur = cur_neg ? (~smp_u + DW'(1)) : smp_u;

  assign sign_flip = smp_vld && prev_ok_q && (cur_neg != prev_neg_q);
  assign pk_pass   = (run_pk_q >= thr);

  if (KIND == ZC_VOLT) begin : g_volt
    assign gate = pk_pass;

    AST_VOLT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> ($past(run_pk_q) >= $past(thr))); // R5
  end else begin : g_curr
    assign gate = 1'b1;

    AST_CURR_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && prev_ok_q && (smp[DW-1] != prev_neg_q)) |=> evt_q); // R6
  end

  assign fire = sign_flip && gate;

  // next state
  always_comb begin
    prev_ok_d  = prev_ok_q;
    prev_neg_d = prev_neg_q;
    run_pk_d   = run_pk_q;
    amp_d      = amp_q;
    evt_d      = fire;
    if (smp_vld) begin
      prev_ok_d  = 1'b1;
      prev_neg_d = cur_neg;
      if (sign_flip || !prev_ok_q) begin
        run_pk_d = abs_cur;
      end else if (abs_cur > run_pk_q) begin
        run_pk_d = abs_cur;
      end
    end
    if (sign_flip) begin
      amp_d = pk_pass;
    end
  end

  // registers, enable on strobe for sample state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok_q  <= 1'b0;
      prev_neg_q <= 1'b0;
      run_pk_q   <= '0;
    end else if (smp_vld) begin
      prev_ok_q  <= prev_ok_d;
      prev_neg_q <= prev_neg_d;
      run_pk_q   <= run_pk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      amp_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      amp_q <= amp_d;
    end
  end

  assign evt    = evt_q;
  assign amp_ok = amp_q;

  AST_EVT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(smp_vld)); // R3

  AST_NO_EVT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(prev_ok_q)); // R2

  AST_AMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> $stable(amp_q)); // R7

  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(prev_neg_q)); // R4

endmodule

// File: rtl/zc_bank.sv
module zc_bank
  import zc_pkg::*;
#(
  parameter int unsigned DW       = ZC_DW_DEF,
  parameter int unsigned NPH      = ZC_NPH_DEF,
  parameter int unsigned STAT_LSB = ZC_STAT_LSB_DEF,
  localparam int unsigned NCH     = 2 * NPH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          smp_vld,
  input  logic [NCH*DW-1:0]       smp_data,
  input  logic [DW-1:0]           full_scale,
  output logic [NCH-1:0]          zc_evt,
  output logic [NCH-1:0]          amp_ok,
  output logic [STAT_LSB+NCH-1:0] zc_stat_word
);

  logic          rst_n_int;
  logic [DW-1:0] thr;

  zc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  zc_thresh #(.DW(DW)) u_thr (
    .full_scale (full_scale),
    .thr        (thr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam zc_kind_e KIND = (k < NPH) ? ZC_VOLT : ZC_CURR;
    zc_chan #(.DW(DW), .KIND(KIND)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .smp_vld (smp_vld[k]),
      .smp     ($signed(smp_data[k*DW +: DW])),
      .thr     (thr),
      .evt     (zc_evt[k]),
      .amp_ok  (amp_ok[k])
    );
  end

  // order VA, VB, VC, IA, IB, IC from STAT_LSB upward
  assign zc_stat_word = {zc_evt, {STAT_LSB{1'b0}}};

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |=> (zc_evt == '0)); // R1

endmodule

// File: tb/tb_zc_bank.sv
`timescale 1ns/1ps
module tb_zc_bank;

  localparam int DW  = 24;
  localparam int NPH = 3;
  localparam int NCH = 2 * NPH;
  localparam int SL  = 9;
  localparam int FS  = 1000000;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    smp_vld;
  logic [NCH*DW-1:0] smp_data;
  logic [DW-1:0]     full_scale;
  logic [NCH-1:0]    zc_evt;
  logic [NCH-1:0]    amp_ok;
  logic [SL+NCH-1:0] zc_stat_word;

  zc_bank #(.DW(DW), .NPH(NPH), .STAT_LSB(SL)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_vld      (smp_vld),
    .smp_data     (smp_data),
    .full_scale   (full_scale),
    .zc_evt       (zc_evt),
    .amp_ok       (amp_ok),
    .zc_stat_word (zc_stat_word)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk;
  int n_bad;
  bit done;

  // reference model state
  int  vals [NCH];
  bit  m_pok [NCH];
  bit  m_neg [NCH];
  int  m_pk  [NCH];
  bit  m_amp [NCH];
  logic [NCH-1:0] amp_exp;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_data();
    for (int k = 0; k < NCH; k++) smp_data[k*DW +: DW] = DW'(vals[k]);
  endtask

  // one strobe on the channels in mask, outputs due one clock later
  task automatic step(input logic [NCH-1:0] mask, input string req);
    logic [NCH-1:0] evt_exp;
    evt_exp = '0;
    for (int k = 0; k < NCH; k++) begin
      if (mask[k]) begin
        bit neg;
        neg = (vals[k] < 0);
        if (m_pok[k] && (neg != m_neg[k])) begin
          bit pass;
          pass = (m_pk[k] >= FS / 10);
          m_amp[k] = pass;
          if (k >= NPH || pass) evt_exp[k] = 1'b1;
          m_pk[k] = iabs(vals[k]);
        end else if (!m_pok[k] || iabs(vals[k]) > m_pk[k]) begin
          m_pk[k] = iabs(vals[k]);
        end
        m_pok[k] = 1'b1;
        m_neg[k] = neg;
      end
      amp_exp[k] = m_amp[k];
    end
    @(negedge clk);
    drive_data();
    smp_vld = mask;
    @(negedge clk);
    smp_vld = '0;
    check(req, "zc_evt", zc_evt, evt_exp);
    check("R7", "amp_ok", amp_ok, amp_exp);
    check("R8", "zc_stat_word", zc_stat_word, {evt_exp, {SL{1'b0}}});
    @(negedge clk);
    check("R3", "pulse width", zc_evt, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_vld = '0; full_scale = DW'(FS);
    for (int k = 0; k < NCH; k++) begin
      vals[k] = 0; m_pok[k] = 0; m_neg[k] = 0; m_pk[k] = 0; m_amp[k] = 0;
    end
    drive_data();
    repeat (3) @(negedge clk);
    check("R1", "evt in reset", zc_evt, 0);
    check("R1", "amp in reset", amp_ok, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "stat after reset", zc_stat_word, 0);
  endtask

  task automatic t_first();
    vals[0] = 500000; vals[1] = 50000; vals[2] = 400000;
    vals[3] = 1;      vals[4] = -5;    vals[5] = 300000;
    step('1, "R2");
  endtask

  task automatic t_volt_big();
    vals[0] = -500000; step(6'h01, "R3");
    vals[0] = 480000;  step(6'h01, "R3");
  endtask

  task automatic t_same_sign();
    vals[0] = 200000; step(6'h01, "R4");
  endtask

  task automatic t_ignored();
    @(negedge clk);
    vals[0] = -300000; drive_data(); smp_vld = '0;
    @(negedge clk);
    check("R4", "unstrobed evt", zc_evt, 0);
    @(negedge clk);
    check("R4", "unstrobed amp", amp_ok, amp_exp);
    vals[0] = 100000; step(6'h01, "R4");
  endtask

  task automatic t_small_volt();
    vals[1] = -50000; step(6'h02, "R5");
    vals[1] = 110000; step(6'h02, "R5");
    vals[1] = -20000; step(6'h02, "R5");
  endtask

  task automatic t_curr_small();
    vals[3] = -1; step(6'h08, "R6");
    vals[3] = 1;  step(6'h08, "R6");
  endtask

  task automatic t_zero();
    vals[4] = 0; step(6'h10, "R3");
    vals[4] = 0; step(6'h10, "R4");
  endtask

  task automatic t_parallel();
    vals[2] = -400000; vals[5] = -300000; vals[0] = 100;
    step(6'h25, "R9");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    smp_data = '0;
    amp_exp = '0;
    t_reset();
    t_first();
    t_volt_big();
    t_same_sign();
    t_ignored();
    t_small_volt();
    t_curr_small();
    t_zero();
    t_parallel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule